// File: doc/BRIEF.md
# Multi-Port Byte Register Bank

This block is a small register file of byte-wide entries shared by several client modules at once. It has a fixed 8-bit address, so up to 256 locations can be addressed. The number of entries that actually exist is a parameter and may be smaller. Every read port has its own selector, so any number of clients can read any entry in the same cycle without arbitration. Every write port has its own address compare, so writers aimed at different entries all complete in the same cycle.

When two or more writers aim at the same entry in one cycle, a fixed priority lets exactly one of them update it. Port 0 is the strongest, and priority falls as the port index rises. Each overridden writer sees a collision flag in the cycle of its write. The bank never replays or queues a lost write; the client logic decides what to do about it.

Nothing in the bank carries a valid/ready handshake. A write request is a plain enable and is always accepted in its cycle, so there is no back-pressure toward writers. Reads are purely combinational selects with no request at all.

Top module: `multiport_regbank`

## Requirements
- R1: A synchronous active-high reset clears every entry, so after reset every in-range read returns 0.
- R2: Each read port independently returns, combinationally and in the same cycle, the current content of the entry its address selects; all read ports may select any entries at once.
- R3: A write with its enable high updates the entry on the rising clock edge. A read of that entry in the same cycle still returns the old value (no write-through).
- R4: Writers aimed at distinct in-range addresses all update their entries on the same edge.
- R5: When several enabled writers aim at the same in-range address, only the lowest-numbered port's data is stored.
- R6: A write port's collision output is high in the same cycle, without a register, exactly when its enable is high, its address is in range, and a lower-numbered enabled port targets the same address. The winning port's flag stays low.
- R7: A write whose address is at or above the entry count changes no entry and raises no collision on any port. A read from such an address returns 0.
- R8: A lost write is not retried. In the following cycles the entry holds the winner's data until a new write lands.
- R9: A port with its enable low neither writes nor raises its collision output, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_WR | Per-port write enable |
| wr_addr | input | N_WR x 8 | Per-port write address |
| wr_data | input | N_WR x DATA_W | Per-port write data |
| wr_collide | output | N_WR | Per-port flag: this write was overridden in this cycle |
| rd_addr | input | N_RD x 8 | Per-port read address |
| rd_data | output | N_RD x DATA_W | Per-port read data, combinational |

## Verification
Two things can fall in the same cycle: several writes aimed at one entry, and a read of an entry that is being written. Directed cycles drive all writers at a single address while a reader watches that same entry. Random cycles draw addresses from a small window just past the entry count, so collisions and out-of-range accesses happen often. A behavioural model in the bench is compared on every clock. It predicts each collision flag from the port ordering, predicts each read from the model state before the edge, and applies only the strongest writer to that state.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  // Address width is fixed: every client sees a 256-location address space.
  localparam int unsigned RB_ADDR_W = 8;

  typedef logic [RB_ADDR_W-1:0] rb_addr_t;

  // True when the address selects an entry that physically exists.
  function automatic logic rb_in_range(input rb_addr_t a, input int unsigned depth);
    return (32'(a) < depth);
  endfunction
endpackage

// File: rtl/rb_wr_priority.sv
module rb_wr_priority
  import regbank_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned N_WR  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_WR-1:0]      wr_en,
  input  rb_addr_t [N_WR-1:0]  wr_addr,
  output logic [N_WR-1:0]      win,
  output logic [N_WR-1:0]      collide
);
  logic [N_WR-1:0] live;

  for (genvar j = 0; j < N_WR; j++) begin : g_live
    assign live[j] = wr_en[j] && rb_in_range(wr_addr[j], DEPTH);
  end

  for (genvar j = 0; j < N_WR; j++) begin : g_port
    logic [N_WR-1:0] stronger_hit;
    always_comb begin
      stronger_hit = '0;
      for (int k = 0; k < j; k++) begin
        stronger_hit[k] = live[k] && (wr_addr[k] == wr_addr[j]);
      end
    end
    assign win[j]     = live[j] && (stronger_hit == '0);
    assign collide[j] = live[j] && (stronger_hit != '0);

    // R9: an idle port is never flagged and never wins
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !wr_en[j] |-> (!win[j] && !collide[j]));

    // R7: out-of-range requests neither win nor collide
    p_oob_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en[j] && (32'(wr_addr[j]) >= DEPTH)) |-> (!win[j] && !collide[j]));

    // R5: two winners can never share an address
    for (genvar k = j + 1; k < N_WR; k++) begin : g_pair
      p_single_winner_r5: assert property (@(posedge clk) disable iff (rst)
        !(win[j] && win[k] && (wr_addr[j] == wr_addr[k])));
    end
  end

  // R6: port 0 can never be overridden
  p_top_never_collides_r6: assert property (@(posedge clk) disable iff (rst)
    !collide[0]);
endmodule

// File: rtl/rb_store.sv
module rb_store
  import regbank_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned N_WR   = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_WR-1:0]                win,
  input  rb_addr_t [N_WR-1:0]            wr_addr,
  input  logic [N_WR-1:0][DATA_W-1:0]    wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]   q
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              load;
    logic [DATA_W-1:0] next_val;

    // At most one winner per address exists, so the scan order only fixes the mux.
    always_comb begin
      load     = 1'b0;
      next_val = q[e];
      for (int j = N_WR - 1; j >= 0; j--) begin
        if (win[j] && (wr_addr[j] == RB_ADDR_W'(e))) begin
          load     = 1'b1;
          next_val = wr_data[j];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)       q[e] <= '0;
      else if (load) q[e] <= next_val;
    end

    // R1: reset leaves the entry cleared
    p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (q[e] == '0));

    // R8: without a winning write the entry keeps its value
    p_hold_no_retry_r8: assert property (@(posedge clk) disable iff (rst)
      (win == '0) |=> $stable(q[e]));
  end

  // R3: the strongest port's data lands on the next edge at its address
  for (genvar e = 0; e < DEPTH; e++) begin : g_land
    p_port0_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (win[0] && (wr_addr[0] == RB_ADDR_W'(e))) |=> (q[e] == $past(wr_data[0])));
  end
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux
  import regbank_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DEPTH-1:0][DATA_W-1:0]  q,
  input  rb_addr_t                      rd_addr,
  output logic [DATA_W-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_addr == RB_ADDR_W'(e)) rd_data = q[e];
    end
  end

  // R7: a read past the last entry returns zero
  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rb_in_range(rd_addr, DEPTH) |-> (rd_data == '0));
endmodule

// File: rtl/multiport_regbank.sv
module multiport_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned N_RD   = 3,
  parameter int unsigned N_WR   = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_WR-1:0]                 wr_en,
  input  logic [N_WR-1:0][RB_ADDR_W-1:0]  wr_addr,
  input  logic [N_WR-1:0][DATA_W-1:0]     wr_data,
  output logic [N_WR-1:0]                 wr_collide,
  input  logic [N_RD-1:0][RB_ADDR_W-1:0]  rd_addr,
  output logic [N_RD-1:0][DATA_W-1:0]     rd_data
);
  logic [N_WR-1:0]                 win;
  logic [DEPTH-1:0][DATA_W-1:0]    q;

  rb_wr_priority #(.DEPTH(DEPTH), .N_WR(N_WR)) u_prio (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .win     (win),
    .collide (wr_collide)
  );

  rb_store #(.DEPTH(DEPTH), .N_WR(N_WR), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .win     (win),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .q       (q)
  );

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    rb_read_mux #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mux (
      .clk     (clk),
      .rst     (rst),
      .q       (q),
      .rd_addr (rd_addr[r]),
      .rd_data (rd_data[r])
    );
  end

  // R6: a flagged port always has a stronger enabled port on its address
  for (genvar j = 1; j < N_WR; j++) begin : g_coll_chk
    p_flag_needs_rival_r6: assert property (@(posedge clk) disable iff (rst)
      wr_collide[j] |-> (wr_en[j] && ((win & ~(N_WR'(1) << j)) != '0)));
  end
endmodule

// File: tb/multiport_regbank_bench.sv
module multiport_regbank_bench;
  localparam int DEPTH  = 16;
  localparam int N_RD   = 3;
  localparam int N_WR   = 3;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_WR-1:0]             wr_en   = '0;
  logic [N_WR-1:0][7:0]        wr_addr = '0;
  logic [N_WR-1:0][DATA_W-1:0] wr_data = '0;
  logic [N_WR-1:0]             wr_collide;
  logic [N_RD-1:0][7:0]        rd_addr = '0;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int model [DEPTH];

  always #2 clk = ~clk;

  multiport_regbank #(.DEPTH(DEPTH), .N_RD(N_RD), .N_WR(N_WR), .DATA_W(DATA_W))
    u_multiport_regbank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_collide(wr_collide), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Inputs are already set (after a negedge); compare, then advance the model.
  task automatic step(input string tag);
    bit live [N_WR];
    #1;
    for (int j = 0; j < N_WR; j++) live[j] = wr_en[j] && (int'(wr_addr[j]) < DEPTH);
    for (int j = 0; j < N_WR; j++) begin
      bit exp_c = 1'b0;
      for (int k = 0; k < j; k++)
        if (live[k] && live[j] && wr_addr[k] == wr_addr[j]) exp_c = 1'b1;
      check("R6", $sformatf("%s collide[%0d]", tag, j), int'(wr_collide[j]), int'(exp_c));
    end
    for (int r = 0; r < N_RD; r++) begin
      int exp_d = (int'(rd_addr[r]) < DEPTH) ? model[int'(rd_addr[r])] : 0;
      check(tag, $sformatf("rd_data[%0d] @%0d", r, rd_addr[r]), int'(rd_data[r]), exp_d);
    end
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) model[e] = 0;
    end else begin
      for (int j = N_WR - 1; j >= 0; j--)
        if (live[j]) model[int'(wr_addr[j])] = int'(wr_data[j]);
    end
    @(negedge clk);
  endtask

  task automatic idle_all();
    wr_en = '0;
  endtask

  initial begin
    for (int e = 0; e < DEPTH; e++) model[e] = 0;
    @(negedge clk);
    // R1: reset clears every entry
    step("R1");
    step("R1");
    rst = 1'b0;
    for (int r = 0; r < N_RD; r++) rd_addr[r] = 8'(r * 5);
    step("R1");

    // R4: distinct addresses written together
    for (int j = 0; j < N_WR; j++) begin
      wr_en[j] = 1'b1; wr_addr[j] = 8'(j + 2); wr_data[j] = 8'(8'h30 + j);
    end
    for (int r = 0; r < N_RD; r++) rd_addr[r] = 8'(r + 2);
    step("R4");
    idle_all();
    step("R4");

    // R3: read the entry being written in the same cycle -> old value
    wr_en[0] = 1'b1; wr_addr[0] = 8'd3; wr_data[0] = 8'hA5;
    rd_addr[0] = 8'd3; rd_addr[1] = 8'd3; rd_addr[2] = 8'd2;
    step("R3");
    idle_all();
    step("R3");

    // R5 / R6: all writers on one address, readers watch it
    for (int j = 0; j < N_WR; j++) begin
      wr_en[j] = 1'b1; wr_addr[j] = 8'd9; wr_data[j] = 8'(8'h70 + j);
    end
    for (int r = 0; r < N_RD; r++) rd_addr[r] = 8'd9;
    step("R5");
    // ports 1 and 2 collide, port 0 idle
    wr_en[0] = 1'b0; wr_addr[1] = 8'd11; wr_addr[2] = 8'd11;
    rd_addr[1] = 8'd11;
    step("R5");
    // R8: loser is not replayed
    idle_all();
    step("R8");
    step("R8");

    // R7: out-of-range writes and reads
    wr_en = '1;
    wr_addr[0] = 8'(DEPTH); wr_addr[1] = 8'(DEPTH); wr_addr[2] = 8'hFF;
    wr_data = '1;
    rd_addr[0] = 8'(DEPTH); rd_addr[1] = 8'hFF; rd_addr[2] = 8'd0;
    step("R7");
    idle_all();
    rd_addr[2] = 8'(DEPTH - 1);
    step("R7");

    // R9: disabled ports aimed at a live entry do nothing
    wr_en = '0; wr_addr = '{8'd9, 8'd9, 8'd9}; wr_data = '{8'h11, 8'h22, 8'h33};
    rd_addr[0] = 8'd9;
    step("R9");
    step("R9");

    // R2: random mix, window past DEPTH to hit collisions and out-of-range
    for (int n = 0; n < 3000; n++) begin
      for (int j = 0; j < N_WR; j++) begin
        wr_en[j]   = 1'($urandom_range(0, 1));
        wr_addr[j] = 8'($urandom_range(0, DEPTH + 3));
        wr_data[j] = 8'($urandom_range(0, 255));
      end
      for (int r = 0; r < N_RD; r++) rd_addr[r] = 8'($urandom_range(0, DEPTH + 3));
      step("R2");
    end

    // R1: reset again after traffic
    idle_all();
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    for (int r = 0; r < N_RD; r++) rd_addr[r] = 8'(r + 7);
    step("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule